// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It receives the instruction word sitting in the decode stage with its valid bit. From that word it builds a compact record of register usage: which sources are read, which register is written, and whether the instruction is a load. It carries that record through shadow copies of the execute, memory and write-back pipeline registers, in step with the datapath.

Each cycle it compares the two source registers of the instruction in execute against the destinations held in the memory-stage and write-back-stage records. From that comparison it drives the selects of the two ALU operand multiplexers, so a result reaches a dependent instruction before the register file is written. When a load sits in execute and the decode-stage instruction reads its destination, bypassing cannot help. The unit then raises a stall, which holds the program counter and the decode register and turns the next execute entry into a bubble. The dependent instruction therefore loses exactly one cycle.

Top module: `hzd_fwd_unit`

## Requirements
- R1: Fields are decoded by format: opcode in bits 31:26 and first source in bits 25:21. Register-register opcode 6'h00 reads bits 20:16 as second source and writes bits 15:11. Load (6'h23) and add-immediate (6'h08) write bits 20:16 and read only the first source. Store (6'h2B) reads both sources and writes nothing. Branch-on-zero (6'h04) reads only the first source. Every other opcode reads and writes nothing. For these purposes bits 15:11 of a load are immediate bits and are never a destination.
- R2: An operand select is 2'b00 (register file) when neither later stage writes that source register; the code 2'b11 never appears.
- R3: When the memory-stage record writes the source register of an operand in execute, that operand's select is 2'b10.
- R4: When only the write-back-stage record writes that source register, the select is 2'b01.
- R5: When both later stages write the same source register, the memory-stage value (2'b10) is selected.
- R6: The stall output is high in the same cycle that a valid load in execute writes a register read by the valid decode-stage instruction. It is never high for any other reason, and never for two cycles in a row.
- R7: Register 0 is never a bypass source and never causes a stall, whether as a source or as a destination.
- R8: A stall places a bubble in execute on the next edge and the held instruction enters execute one cycle later. In that cycle the load result is bypassed from write-back (2'b01).
- R9: A source field that the opcode does not read gives select 2'b00 and causes no stall, even if its bits equal a pending destination.
- R10: A decode-stage slot with valid low enters execute as a bubble and never raises a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid_i | input | 1 | Decode-stage register holds a real instruction |
| id_instr_i | input | 32 | Instruction word in the decode-stage register |
| stall_o | output | 1 | Hold PC and decode register, insert bubble into execute |
| fwd_a_o | output | 2 | First ALU operand select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_o | output | 2 | Second ALU operand select, same encoding |

## Verification
The bench builds the unit with its default parameters: two operand ports and a two-stage reset synchronizer. It checks the stall and both selects every cycle against a shadow pipeline of its own. Random programs draw registers only from 0 to 7, so same-register collisions between adjacent, two-apart and three-apart instructions, writes to register 0 and back-to-back loads arise often. Directed sequences cover add chains with distances 1, 2 and 3, double matches, load-use on either source, a load whose immediate bits mimic a destination, and invalid decode slots.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned RADDR_W   = 5;
  localparam int unsigned SRC_PORTS = 2;

  // field positions, fixed by the instruction formats
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned F1_LSB  = OPC_LSB - RADDR_W;
  localparam int unsigned F2_LSB  = F1_LSB - RADDR_W;
  localparam int unsigned F3_LSB  = F2_LSB - RADDR_W;

  localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BRZ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI   = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;

  typedef logic [RADDR_W-1:0] reg_id_t;

  typedef struct packed {
    logic    valid;
    logic    writes;
    logic    is_load;
    reg_id_t dst;
    reg_id_t src_a;
    reg_id_t src_b;
    logic    use_a;
    logic    use_b;
  } stage_t;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hzd_decode.sv
module hzd_decode
  import hzd_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output stage_t             rec_o
);
  logic [OPC_W-1:0] opc;
  reg_id_t          f1, f2, f3, dst_raw;
  logic             rd_a, rd_b, wr, ld;

  always_comb begin
    opc  = instr_i[OPC_LSB +: OPC_W];
    f1   = instr_i[F1_LSB +: RADDR_W];
    f2   = instr_i[F2_LSB +: RADDR_W];
    f3   = instr_i[F3_LSB +: RADDR_W];
    rd_a = 1'b0;
    rd_b = 1'b0;
    wr   = 1'b0;
    ld   = 1'b0;
    dst_raw = '0;
    unique case (opc)
      OPC_REGREG: begin rd_a = 1'b1; rd_b = 1'b1; wr = 1'b1; dst_raw = f3; end
      OPC_ADDI:   begin rd_a = 1'b1; wr = 1'b1; dst_raw = f2; end
      OPC_LOAD:   begin rd_a = 1'b1; wr = 1'b1; ld = 1'b1; dst_raw = f2; end
      OPC_STORE:  begin rd_a = 1'b1; rd_b = 1'b1; end
      OPC_BRZ:    begin rd_a = 1'b1; end
      default:    begin end
    endcase
  end

  always_comb begin
    rec_o.valid   = valid_i;
    rec_o.writes  = valid_i & wr & (dst_raw != '0);
    rec_o.is_load = valid_i & ld;
    rec_o.dst     = (wr && dst_raw != '0) ? dst_raw : '0;
    rec_o.src_a   = f1;
    rec_o.src_b   = f2;
    rec_o.use_a   = valid_i & rd_a & (f1 != '0);
    rec_o.use_b   = valid_i & rd_b & (f2 != '0);
  end
endmodule

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall_i,
  input  stage_t id_rec_i,
  output stage_t ex_q,
  output stage_t mem_q,
  output stage_t wb_q
);
  stage_t ex_d, mem_d, wb_d;

  always_comb begin
    ex_d  = stall_i ? stage_t'('0) : id_rec_i;
    mem_d = ex_q;
    wb_d  = mem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
    end
  end
endmodule

// File: rtl/hzd_lu_detect.sv
module hzd_lu_detect
  import hzd_pkg::*;
(
  input  stage_t id_rec_i,
  input  stage_t ex_rec_i,
  output logic   stall_o
);
  logic hit_a, hit_b, load_pending;

  always_comb begin
    load_pending = ex_rec_i.valid & ex_rec_i.is_load & ex_rec_i.writes;
    hit_a   = id_rec_i.use_a & (id_rec_i.src_a == ex_rec_i.dst);
    hit_b   = id_rec_i.use_b & (id_rec_i.src_b == ex_rec_i.dst);
    stall_o = id_rec_i.valid & load_pending & (hit_a | hit_b);
  end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
(
  input  logic     use_i,
  input  reg_id_t  src_i,
  input  stage_t   mem_rec_i,
  input  stage_t   wb_rec_i,
  output fwd_sel_e sel_o
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = use_i & mem_rec_i.valid & mem_rec_i.writes & (mem_rec_i.dst == src_i);
    wb_hit  = use_i & wb_rec_i.valid  & wb_rec_i.writes  & (wb_rec_i.dst  == src_i);
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid_i,
  input  logic [INSTR_W-1:0] id_instr_i,
  output logic               stall_o,
  output logic [1:0]         fwd_a_o,
  output logic [1:0]         fwd_b_o
);
  logic     rst_n_s;
  stage_t   id_rec, ex_q, mem_q, wb_q;
  logic     stall;
  logic     op_use [SRC_PORTS];
  reg_id_t  op_src [SRC_PORTS];
  fwd_sel_e op_sel [SRC_PORTS];

  hzd_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  hzd_decode u_dec (
    .valid_i(id_valid_i), .instr_i(id_instr_i), .rec_o(id_rec)
  );

  hzd_lu_detect u_lu (
    .id_rec_i(id_rec), .ex_rec_i(ex_q), .stall_o(stall)
  );

  hzd_track u_trk (
    .clk(clk), .rst_n(rst_n_s), .stall_i(stall), .id_rec_i(id_rec),
    .ex_q(ex_q), .mem_q(mem_q), .wb_q(wb_q)
  );

  always_comb begin
    op_use[0] = ex_q.valid & ex_q.use_a;
    op_src[0] = ex_q.src_a;
    op_use[1] = ex_q.valid & ex_q.use_b;
    op_src[1] = ex_q.src_b;
  end

  for (genvar g = 0; g < SRC_PORTS; g++) begin : g_op
    hzd_fwd_pick u_pick (
      .use_i(op_use[g]), .src_i(op_src[g]),
      .mem_rec_i(mem_q), .wb_rec_i(wb_q), .sel_o(op_sel[g])
    );
  end

  assign stall_o = stall;
  assign fwd_a_o = op_sel[0];
  assign fwd_b_o = op_sel[1];
endmodule

// File: rtl/hzd_fwd_unit_chk.sv
module hzd_fwd_unit_chk
  import hzd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b,
  input stage_t     ex_st,
  input stage_t     mem_st,
  input stage_t     wb_st
);
  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  p_zero_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_st.src_a == '0) |-> (fwd_a == 2'b00));

  p_unused_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_st.use_b |-> (fwd_b == 2'b00));

  p_newest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_st.valid && ex_st.use_a && mem_st.writes && mem_st.dst == ex_st.src_a)
      |-> (fwd_a == 2'b10));

  p_wb_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_st.valid && ex_st.use_b && wb_st.writes && wb_st.dst == ex_st.src_b &&
     !(mem_st.writes && mem_st.dst == ex_st.src_b)) |-> (fwd_b == 2'b01));

  p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_st.is_load && ex_st.writes));

  p_one_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_st.valid);
endmodule

bind hzd_fwd_unit hzd_fwd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .stall(stall_o), .fwd_a(fwd_a_o), .fwd_b(fwd_b_o),
  .ex_st(ex_q), .mem_st(mem_q), .wb_st(wb_q)
);

// File: tb/hzd_fwd_unit_tb.sv
module hzd_fwd_unit_tb;
  localparam int PROG_MAX = 600;

  logic        clk, rst_n, id_valid;
  logic [31:0] id_instr;
  logic        stall;
  logic [1:0]  fwd_a, fwd_b;

  hzd_fwd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid), .id_instr_i(id_instr),
    .stall_o(stall), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit       valid, wr, ld, rda, rdb;
    bit [4:0] rd, ra, rb, f3;
  } bst_t;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit [32:0] prog [PROG_MAX];
  int plen = 0;

  function automatic bit [31:0] e_rr(int d, int a, int b);
    return {6'h00, 5'(a), 5'(b), 5'(d), 11'h020};
  endfunction
  function automatic bit [31:0] e_ri(bit [5:0] op, int d, int a, bit [15:0] imm);
    return {op, 5'(a), 5'(d), imm};
  endfunction

  function automatic bst_t bdec(bit v, bit [31:0] w);
    bst_t s;
    bit [5:0] op = w[31:26];
    bit [4:0] dst = 0;
    s = '{default: 0};
    s.valid = v;
    s.ra = w[25:21]; s.rb = w[20:16]; s.f3 = w[15:11];
    case (op)
      6'h00: begin s.rda = 1; s.rdb = 1; dst = w[15:11]; s.wr = 1; end
      6'h08: begin s.rda = 1; dst = w[20:16]; s.wr = 1; end
      6'h23: begin s.rda = 1; dst = w[20:16]; s.wr = 1; s.ld = 1; end
      6'h2B: begin s.rda = 1; s.rdb = 1; end
      6'h04: begin s.rda = 1; end
      default: ;
    endcase
    if (!v) begin s.rda = 0; s.rdb = 0; s.wr = 0; s.ld = 0; end
    if (dst == 0) s.wr = 0;
    s.rd = s.wr ? dst : 5'd0;
    return s;
  endfunction

  function automatic int efwd(bst_t ex, bst_t mem, bst_t wb, bit opb);
    bit rdx = opb ? ex.rdb : ex.rda;
    bit [4:0] src = opb ? ex.rb : ex.ra;
    if (!ex.valid || !rdx || src == 0) return 0;
    if (mem.valid && mem.wr && mem.rd == src) return 2;
    if (wb.valid && wb.wr && wb.rd == src) return 1;
    return 0;
  endfunction

  function automatic string ftag(bst_t ex, bst_t mem, bst_t wb, bit opb);
    bit rdx = opb ? ex.rdb : ex.rda;
    bit [4:0] src = opb ? ex.rb : ex.ra;
    bit hm, hw;
    if (!ex.valid || !rdx) return "R9";
    if (src == 0) return "R7";
    hm = mem.valid && mem.wr && mem.rd == src;
    hw = wb.valid && wb.wr && wb.rd == src;
    if (hm && hw) return "R5";
    if (hm) return "R3";
    if (hw) return "R4";
    return "R2";
  endfunction

  function automatic int estall(bst_t id, bst_t ex);
    if (!id.valid || !ex.valid || !ex.ld || !ex.wr) return 0;
    if (id.rda && id.ra != 0 && id.ra == ex.rd) return 1;
    if (id.rdb && id.rb != 0 && id.rb == ex.rd) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(bit v, bit [31:0] w);
    prog[plen] = {v, w};
    plen++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    bst_t m_ex, m_mem, m_wb, cur;
    int pc = 0;
    bit prev_stall = 0;
    string stag;
    int es;
    void'($urandom(32'd20240611));

    // directed: add chain with distances 1, 2, 3
    push(1, e_rr(1, 2, 3));
    push(1, e_rr(4, 1, 5));
    push(1, e_rr(6, 7, 1));
    push(1, e_rr(8, 1, 1));
    // double match on r2
    push(1, e_rr(2, 3, 3));
    push(1, e_rr(2, 4, 4));
    push(1, e_rr(5, 2, 2));
    // register 0 as destination and source
    push(1, e_rr(0, 1, 1));
    push(1, e_rr(7, 0, 0));
    // load-use on first source
    push(1, e_ri(6'h23, 3, 4, 16'h0010));
    push(1, e_rr(10, 3, 5));
    // load-use on store data source
    push(1, e_ri(6'h23, 11, 1, 16'h0004));
    push(1, e_ri(6'h2B, 11, 2, 16'h0008));
    // load then use two apart: no stall
    push(1, e_ri(6'h23, 12, 1, 16'h0000));
    push(1, 32'hFC00_0000);
    push(1, e_rr(13, 12, 0));
    // load to r0
    push(1, e_ri(6'h23, 0, 1, 16'h0000));
    push(1, e_rr(5, 0, 0));
    // load whose immediate bits 15:11 look like r15
    push(1, e_ri(6'h23, 14, 1, {5'd15, 11'd0}));
    push(1, e_rr(16, 15, 15));
    // add-immediate whose dest field equals pending destination
    push(1, e_rr(20, 1, 2));
    push(1, e_ri(6'h08, 20, 3, 16'h0001));
    // invalid slot after a load
    push(1, e_ri(6'h23, 21, 1, 16'h0000));
    push(0, e_rr(22, 21, 21));
    push(1, 32'hFC00_0000);
    // random program
    while (plen < PROG_MAX) begin
      int k = $urandom_range(0, 6);
      int d = $urandom_range(0, 7), a = $urandom_range(0, 7), b = $urandom_range(0, 7);
      bit [15:0] imm = 16'($urandom);
      bit v = ($urandom_range(0, 9) != 0);
      case (k)
        0, 1: push(v, e_rr(d, a, b));
        2:    push(v, e_ri(6'h08, d, a, imm));
        3, 4: push(v, e_ri(6'h23, d, a, imm));
        5:    push(v, e_ri(6'h2B, d, a, imm));
        default: push(v, ($urandom_range(0, 1) == 0) ? e_ri(6'h04, d, a, imm) : {6'h3F, 26'($urandom)});
      endcase
    end

    // reset
    rst_n = 1'b0; id_valid = 1'b1; id_instr = e_rr(1, 1, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset fwd_a", fwd_a, 0);
    chk("R2", "reset fwd_b", fwd_b, 0);
    chk("R6", "reset stall", stall, 0);
    id_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    m_ex = '{default: 0}; m_mem = m_ex; m_wb = m_ex;
    while (pc < plen + 4) begin
      if (pc < plen) begin
        id_valid = prog[pc][32];
        id_instr = prog[pc][31:0];
      end else begin
        id_valid = 1'b0;
        id_instr = 32'hFC00_0000;
      end
      cur = bdec(id_valid, id_instr);
      #1;
      es = estall(cur, m_ex);
      if (prev_stall) stag = "R8";
      else if (!cur.valid) stag = "R10";
      else if (m_ex.ld && m_ex.valid && m_ex.rb == 0) stag = "R7";
      else if (m_ex.ld && m_ex.valid && (m_ex.f3 == cur.ra || m_ex.f3 == cur.rb) && es == 0) stag = "R1";
      else stag = "R6";
      chk(stag, "stall", stall, es);
      chk(ftag(m_ex, m_mem, m_wb, 0), "fwd_a", fwd_a, efwd(m_ex, m_mem, m_wb, 0));
      chk(ftag(m_ex, m_mem, m_wb, 1), "fwd_b", fwd_b, efwd(m_ex, m_mem, m_wb, 1));
      m_wb = m_mem;
      m_mem = m_ex;
      if (es != 0) m_ex = '{default: 0};
      else begin
        m_ex = cur;
        pc++;
      end
      prev_stall = (es != 0);
      @(negedge clk);
    end
    done = 1;
    finish_run();
  end
endmodule